// File: doc/BRIEF.md
# SD Card Clock Enable Generator

This block derives two clock-enable strobes for an SD host interface from one parent clock. A first stage divides the parent clock by a power of two and emits a high-speed enable strobe. A second stage counts those strobes and divides them again by 2 or 4 to emit the card enable strobe. The overall ratio from the parent clock to the card strobe therefore runs from 2 to 64. Each strobe is one parent cycle wide and is meant to drive the enable of downstream logic or a gating cell outside this block.

A single 10-bit control register sets the block up. It holds a first-stage code, a second-stage code and one stop bit per strobe. A stop bit masks only its own strobe, and the counters keep running behind it. Writes that carry an unsupported divider code are refused: the divider codes stay as they were and an error flag rises. An accepted divider change is not applied at once. It is held until the current card-strobe period ends, so both stages start their new count together from zero and no shortened period appears.

Top module: `sdclk_gate_gen`

## Requirements
- R1: While reset is held and right after it, rd_data reads 0x300 (both stop bits set, both codes 0), cfg_err is 0, and hck_en and ck_en stay 0.
- R2: Control register bit positions: bit 9 stops hck_en, bit 8 stops ck_en, bits 4:2 hold the first-stage code, and bits 1:0 hold the second-stage code. Bits 7:5 read 0. rd_data reflects an accepted write one cycle after wr_en.
- R3: First-stage code n (0 to 4) makes hck_en pulse for one cycle every 2^n parent cycles while bit 9 is clear.
- R4: Second-stage code 0 makes ck_en pulse on every 2nd first-stage tick, and code 1 on every 4th. A ck_en pulse always falls in a cycle that is a first-stage tick.
- R5: Each stop bit masks only its own strobe, starting the cycle after the write. The other strobe keeps its timing.
- R6: Setting and then clearing the stop bits leaves the divider codes unchanged, so the strobes resume at the earlier ratio.
- R7: A write whose first-stage code is 5 to 7, or whose second-stage code is 2 or 3, leaves both divider codes unchanged and sets cfg_err the next cycle. Its stop bits are still taken. The next accepted write clears cfg_err.
- R8: Accepted divider codes take effect in the cycle after the first card-strobe boundary (a cycle in which ck_en would pulse if unmasked) that follows the write. Both stages then count from zero, so no period shorter than the old or new ratio appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously by the system |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 10 | Control register write value |
| rd_data | output | 10 | Current control register value |
| cfg_err | output | 1 | Last write carried an unsupported divider code |
| hck_en | output | 1 | High-speed clock enable strobe |
| ck_en | output | 1 | Card clock enable strobe |

## Verification
The register has a single stage, so rd_data and cfg_err must show a write in the first cycle after the edge that samples wr_en. The scoreboard item pushed by the write task is popped at that edge. Stop bits follow the same one-cycle latency. Divider codes do not: they apply only after the next card-strobe boundary. The bench keeps a per-cycle reference of both stage counts and of the boundary at which new codes load. It compares both strobes every cycle, a short delay after the rising edge, so a code that loaded one cycle early or late would show up as a mismatched strobe.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int REG_W      = 10;
  localparam int STOP_H_BIT = 9;
  localparam int STOP_C_BIT = 8;
  localparam int SRC_LSB    = 2;
  localparam int SRC_W      = 3;
  localparam int FIN_LSB    = 0;
  localparam int FIN_W      = 2;

  typedef struct packed {
    logic             stop_h;
    logic             stop_c;
    logic [SRC_W-1:0] src;
    logic [FIN_W-1:0] fin;
  } ctrl_t;

  function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
    logic [REG_W-1:0] v;
    v = '0;
    v[STOP_H_BIT] = c.stop_h;
    v[STOP_C_BIT] = c.stop_c;
    v[SRC_LSB +: SRC_W] = c.src;
    v[FIN_LSB +: FIN_W] = c.fin;
    return v;
  endfunction
endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
  import sdclk_pkg::*;
#(
  parameter int SRC_CODES = 5,
  parameter int FIN_CODES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output ctrl_t            ctrl,
  output logic             cfg_err
);
  ctrl_t            ctrl_q, ctrl_d;
  logic             err_q, err_d;
  logic [SRC_W-1:0] wr_src;
  logic [FIN_W-1:0] wr_fin;
  logic             codes_ok;

  assign wr_src   = wr_data[SRC_LSB +: SRC_W];
  assign wr_fin   = wr_data[FIN_LSB +: FIN_W];
  assign codes_ok = (32'(wr_src) < SRC_CODES) && (32'(wr_fin) < FIN_CODES);

  always_comb begin
    ctrl_d = ctrl_q;
    err_d  = err_q;
    if (wr_en) begin
      ctrl_d.stop_h = wr_data[STOP_H_BIT];
      ctrl_d.stop_c = wr_data[STOP_C_BIT];
      if (codes_ok) begin
        ctrl_d.src = wr_src;
        ctrl_d.fin = wr_fin;
        err_d      = 1'b0;
      end else begin
        err_d      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{stop_h: 1'b1, stop_c: 1'b1, src: '0, fin: '0};
      err_q  <= 1'b0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
      err_q  <= err_d;
    end
  end

  assign ctrl    = ctrl_q;
  assign cfg_err = err_q;

  assert_reject_keeps_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !codes_ok) |=> (cfg_err && $stable(ctrl.src) && $stable(ctrl.fin)));
  assert_accept_clears_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && codes_ok) |=> !cfg_err);
  assert_idle_holds_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ctrl) && $stable(cfg_err)));
endmodule

// File: rtl/sdclk_prescaler.sv
module sdclk_prescaler
  import sdclk_pkg::*;
#(
  parameter int SRC_CODES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] code,
  output logic             tick
);
  localparam int CNT_W = (SRC_CODES > 1) ? SRC_CODES - 1 : 1;
  localparam int DIV_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div;

  assign div  = DIV_W'(1) << code;
  assign tick = ({1'b0, cnt_q} == (div - DIV_W'(1)));

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_q} < div));
endmodule

// File: rtl/sdclk_post_div.sv
module sdclk_post_div
  import sdclk_pkg::*;
#(
  parameter int FIN_CODES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [FIN_W-1:0] code,
  output logic             tick
);
  localparam int CNT_W = (FIN_CODES > 0) ? FIN_CODES : 1;
  localparam int DIV_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div;
  logic             last;

  assign div  = DIV_W'(2) << code;
  assign last = ({1'b0, cnt_q} == (div - DIV_W'(1)));
  assign tick = step && last;

  always_comb begin
    cnt_d = cnt_q;
    if (step) cnt_d = last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_d;
  end

  assert_fin_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_q} < div));
endmodule

// File: rtl/sdclk_gate_gen.sv
module sdclk_gate_gen
  import sdclk_pkg::*;
#(
  parameter int SRC_CODES = 5,
  parameter int FIN_CODES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             cfg_err,
  output logic             hck_en,
  output logic             ck_en
);
  ctrl_t            ctrl;
  logic [SRC_W-1:0] act_src_q, act_src_d;
  logic [FIN_W-1:0] act_fin_q, act_fin_d;
  logic             hck_tick, ck_tick;

  sdclk_ctrl_reg #(.SRC_CODES(SRC_CODES), .FIN_CODES(FIN_CODES)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl(ctrl), .cfg_err(cfg_err));

  sdclk_prescaler #(.SRC_CODES(SRC_CODES)) i_pre (
    .clk(clk), .rst_n(rst_n), .code(act_src_q), .tick(hck_tick));

  sdclk_post_div #(.FIN_CODES(FIN_CODES)) i_post (
    .clk(clk), .rst_n(rst_n), .step(hck_tick), .code(act_fin_q), .tick(ck_tick));

  always_comb begin
    act_src_d = act_src_q;
    act_fin_d = act_fin_q;
    if (ck_tick) begin
      act_src_d = ctrl.src;
      act_fin_d = ctrl.fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_src_q <= '0;
      act_fin_q <= '0;
    end else if (ck_tick) begin
      act_src_q <= act_src_d;
      act_fin_q <= act_fin_d;
    end
  end

  assign rd_data = pack_ctrl(ctrl);
  assign hck_en  = hck_tick && !ctrl.stop_h;
  assign ck_en   = ck_tick && !ctrl.stop_c;

  assert_codes_hold_mid_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_tick |=> ($stable(act_src_q) && $stable(act_fin_q)));
  assert_codes_load_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ck_tick |=> (act_src_q == $past(ctrl.src) && act_fin_q == $past(ctrl.fin)));
  assert_ck_on_hck_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ck_tick |-> hck_tick);
  assert_stop_h_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[STOP_H_BIT]) |=> !hck_en);
  assert_stop_c_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[STOP_C_BIT]) |=> !ck_en);
endmodule

// File: tb/test_sdclk_gate_gen.sv
module test_sdclk_gate_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, wr_en;
  logic [9:0] wr_data;
  logic [9:0] rd_data;
  logic       cfg_err, hck_en, ck_en;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit finished = 0;

  typedef struct { logic [9:0] rd; logic err; } exp_t;
  exp_t sb_q[$];

  // bench-side view of the register contents
  logic [9:0] exp_reg;
  logic       exp_err;

  // reference state for strobe timing
  int m_sh_src, m_sh_fin, m_act_src, m_act_fin, m_sc, m_fc;
  bit m_stop_h, m_stop_c;

  sdclk_gate_gen i_sdclk_gate_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cfg_err(cfg_err), .hck_en(hck_en), .ck_en(ck_en));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_sh_src = 0; m_sh_fin = 0; m_act_src = 0; m_act_fin = 0;
    m_sc = 0; m_fc = 0; m_stop_h = 1; m_stop_c = 1;
  endfunction

  function automatic bit m_htick();
    return m_sc == (1 << m_act_src) - 1;
  endfunction

  function automatic bit m_ctick();
    return m_htick() && (m_fc == (2 << m_act_fin) - 1);
  endfunction

  // advance the reference by one edge given the inputs seen at that edge
  function automatic void model_step(input bit we, input logic [9:0] d);
    bit ht, ct;
    ht = m_htick();
    ct = m_ctick();
    m_sc = ht ? 0 : m_sc + 1;
    if (ht) m_fc = ct ? 0 : m_fc + 1;
    if (ct) begin m_act_src = m_sh_src; m_act_fin = m_sh_fin; end
    if (we) begin
      m_stop_h = d[9];
      m_stop_c = d[8];
      if (d[4:2] <= 3'd4 && d[1:0] <= 2'd1) begin
        m_sh_src = int'(d[4:2]); m_sh_fin = int'(d[1:0]);
      end
    end
  endfunction

  // monitor: a short delay after each rising edge
  always @(posedge clk) begin
    bit we_s;
    logic [9:0] d_s;
    we_s = wr_en; d_s = wr_data;
    #2;
    if (rst_n && !finished) begin
      model_step(we_s, d_s);
      check(cur_req, "hck_en", int'(hck_en), int'(m_htick() && !m_stop_h));
      check(cur_req, "ck_en",  int'(ck_en),  int'(m_ctick() && !m_stop_c));
      if (we_s) begin
        exp_t e;
        if (sb_q.size() == 0) begin
          errors++;
          $display("FAIL R2 scoreboard empty actual=1 expected=0");
        end else begin
          e = sb_q.pop_front();
          check(cur_req, "rd_data", int'(rd_data), int'(e.rd));
          check("R7", "cfg_err", int'(cfg_err), int'(e.err));
        end
      end
    end
  end

  task automatic write_reg(input logic [9:0] d);
    exp_t e;
    @(negedge clk);
    exp_reg[9] = d[9];
    exp_reg[8] = d[8];
    if (d[4:2] <= 3'd4 && d[1:0] <= 2'd1) begin
      exp_reg[4:0] = d[4:0];
      exp_err = 1'b0;
    end else begin
      exp_err = 1'b1;
    end
    e.rd = exp_reg; e.err = exp_err;
    sb_q.push_back(e);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wr_en = 1'b0; wr_data = '0; rst_n = 1'b0;
    exp_reg = 10'h300; exp_err = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "rd_data", int'(rd_data), 32'h300);
    check("R1", "cfg_err", int'(cfg_err), 0);
    check("R1", "hck_en", int'(hck_en), 0);
    check("R1", "ck_en", int'(ck_en), 0);
    rst_n = 1'b1;
    idle(6);

    cur_req = "R3";               // enable at ratio 2
    write_reg(10'h000); idle(12);
    cur_req = "R8";               // src 1, fin 1: ratio 8
    write_reg(10'h005); idle(40);
    cur_req = "R4";               // src 2, fin 0: ratio 8 via other split
    write_reg(10'h008); idle(40);
    cur_req = "R5";               // mask hck only, src 3, fin 1: ratio 32
    write_reg(10'h20D); idle(100);
    cur_req = "R5";               // mask ck only
    write_reg(10'h10D); idle(70);
    cur_req = "R6";               // stop both, codes kept, then resume
    write_reg(10'h30D); idle(70);
    write_reg(10'h00D); idle(100);
    cur_req = "R3";               // largest ratio 64
    write_reg(10'h011); idle(200);
    cur_req = "R7";               // bad first-stage code, stops still taken
    write_reg(10'h31C); idle(10);
    write_reg(10'h01C); idle(140);
    write_reg(10'h002); idle(140);  // bad second-stage code
    cur_req = "R2";
    write_reg(10'h0E0); idle(140);  // bits 7:5 ignored, codes 0/0 accepted
    cur_req = "R8";                 // write right before a boundary
    write_reg(10'h004); idle(3);
    write_reg(10'h010); idle(90);

    finished = 1;
    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule